// File: doc/BRIEF.md
# Branch Clock Gate with Run Status

This block gates one downstream branch clock from its source clock under register control. Software turns the branch on by setting an enable bit in the control register. A second, independent vote register can also turn it on, and so can an external network-on-chip hold input. The clock gate is latch based: the enable is captured only while the source clock is low, so every pulse on the gated output has the full width of a source pulse.

The run request is passed through a synchronizer into the source clock domain before it reaches the gate. The status bits the control register returns are taken from that synchronized state, not from the request. This means software sees the branch as off until the gate is really passing pulses. The same holds in reverse when the branch turns off. A separate status code tells software that the branch runs only because the network-on-chip hold keeps it on.

Top module: `branch_clk_gate`

## Requirements
- R1: After reset the enable and vote bits are 0, the control register reads 0x8000_0000 (status field 4'b1000), and clk_o stays low.
- R2: The control register is at byte address 0x0. Bit 0 is the read/write local enable. Writes to bits 31:1 have no effect, and those bits read as the status field in 31:28 and zero elsewhere.
- R3: The vote register is at byte address 0x4. Bit 0 is read/write, and all other bits read as 0.
- R4: The branch is requested when the local enable, the vote bit or noc_hold_i is 1. Any one of them alone is enough to start clk_o.
- R5: Status bit 31 (off flag) is cleared on the second rising clk_i edge after the edge that sets the request. It is set again on the second rising edge after the request goes away.
- R6: While running, the status field (bits 31:28) reads 4'b0000 if the enable or the vote bit requests the branch. It reads 4'b0010 if only noc_hold_i keeps the branch on. While off it reads 4'b1000. No other value ever appears.
- R7: clk_o is never high while clk_i is low. While the branch is running, every clk_i pulse appears on clk_o. While it is off, clk_o has no rising edge.
- R8: A read of any address other than 0x0 or 0x4 returns 0. A write to such an address changes neither register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Source clock, also the register bus clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sel_i | input | 1 | Bus access strobe |
| we_i | input | 1 | Write when 1, read when 0 |
| addr_i | input | ADDR_W | Byte address |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data, combinational from addr_i |
| noc_hold_i | input | 1 | Network-on-chip hold, keeps the branch on |
| clk_o | output | 1 | Gated branch clock |

## Verification
The bench times the off flag to the cycle after enabling and after disabling. A design that reports status straight from the request, or that has one synchronizer stage too many, would clear the flag one cycle early or one cycle late. It runs the branch from the hold input alone and then adds the local enable. A design that confuses the two reasons would show the wrong code, 0000 instead of 0010, or the reverse. It counts clk_o pulses in windows where the branch is on and where it is off, and it checks that clk_o is low in every low phase of clk_i. Any truncated or extra pulse therefore shows up. Writes to unmapped addresses and to the upper control bits are followed by readback, which catches decode that aliases on the low address bits.

// File: rtl/cg_pkg.sv
package cg_pkg;
  localparam int unsigned STAT_W = 4;
  localparam logic [STAT_W-1:0] STAT_ON       = 4'b0000;
  localparam logic [STAT_W-1:0] STAT_NOC_HELD = 4'b0010;
  localparam logic [STAT_W-1:0] STAT_OFF      = 4'b1000;

  typedef struct packed {
    logic run;
    logic hold_only;
  } gate_req_t;
endpackage

// File: rtl/cg_sync.sv
module cg_sync #(
  parameter int unsigned WIDTH  = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg_q[0] <= '0;
    else         stg_q[0] <= d_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[s] <= '0;
      else         stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/cg_gate.sv
module cg_gate (
  input  logic clk_i,
  input  logic en_i,
  output logic clk_o
);
  logic en_l;

  // transparent in the low phase only: enable cannot change during a pulse
  always_latch begin
    if (!clk_i) en_l <= en_i;
  end

  assign clk_o = clk_i & en_l;
endmodule

// File: rtl/cg_regs.sv
module cg_regs #(
  parameter int unsigned ADDR_W    = 4,
  parameter int unsigned DATA_W    = 32,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 'h0,
  parameter logic [ADDR_W-1:0] VOTE_ADDR = 'h4
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      sel_i,
  input  logic                      we_i,
  input  logic [ADDR_W-1:0]         addr_i,
  input  logic [DATA_W-1:0]         wdata_i,
  input  logic [cg_pkg::STAT_W-1:0] stat_i,
  output logic [DATA_W-1:0]         rdata_o,
  output logic                      en_o,
  output logic                      vote_o
);
  localparam int unsigned STAT_LSB = DATA_W - cg_pkg::STAT_W;

  logic hit_ctrl, hit_vote;
  assign hit_ctrl = addr_i == CTRL_ADDR;
  assign hit_vote = addr_i == VOTE_ADDR;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_o   <= 1'b0;
      vote_o <= 1'b0;
    end else if (sel_i && we_i) begin
      if (hit_ctrl) en_o   <= wdata_i[0];
      if (hit_vote) vote_o <= wdata_i[0];
    end
  end

  always_comb begin
    rdata_o = '0;
    if (hit_ctrl) begin
      rdata_o[DATA_W-1:STAT_LSB] = stat_i;
      rdata_o[0]                 = en_o;
    end else if (hit_vote) begin
      rdata_o[0] = vote_o;
    end
  end
endmodule

// File: rtl/branch_clk_gate.sv
module branch_clk_gate #(
  parameter int unsigned ADDR_W      = 4,
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned SYNC_STAGES = 2,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 'h0,
  parameter logic [ADDR_W-1:0] VOTE_ADDR = 'h4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              noc_hold_i,
  output logic              clk_o
);
  import cg_pkg::*;

  localparam int unsigned REQ_W = $bits(gate_req_t);

  logic              en_q, vote_q;
  gate_req_t         req, req_s;
  logic [STAT_W-1:0] stat;

  cg_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .CTRL_ADDR(CTRL_ADDR), .VOTE_ADDR(VOTE_ADDR)
  ) u_regs (
    .clk_i, .rst_ni, .sel_i, .we_i, .addr_i, .wdata_i,
    .stat_i (stat),
    .rdata_o,
    .en_o   (en_q),
    .vote_o (vote_q)
  );

  assign req.run       = en_q | vote_q | noc_hold_i;
  assign req.hold_only = noc_hold_i & ~en_q & ~vote_q;

  // reason travels with the run bit so both are coherent in the status
  cg_sync #(.WIDTH(REQ_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni,
    .d_i (req),
    .q_o (req_s)
  );

  cg_gate u_gate (
    .clk_i,
    .en_i  (req_s.run),
    .clk_o
  );

  always_comb begin
    if (!req_s.run)         stat = STAT_OFF;
    else if (req_s.hold_only) stat = STAT_NOC_HELD;
    else                    stat = STAT_ON;
  end
endmodule

// File: rtl/branch_clk_gate_chk.sv
module branch_clk_gate_chk #(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 32,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 'h0,
  parameter logic [ADDR_W-1:0] VOTE_ADDR = 'h4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              sel_i,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic              noc_hold_i,
  input logic              en_q,
  input logic              vote_q,
  input logic [3:0]        stat
);
  logic [1:0] age_q;
  logic       req;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         age_q <= '0;
    else if (age_q != 2'd3) age_q <= age_q + 2'd1;
  end
  assign req = en_q | vote_q | noc_hold_i;

  a_r2_ctrl_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i && we_i && addr_i == CTRL_ADDR) |=> en_q == $past(wdata_i[0]));

  a_r3_vote_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i && we_i && addr_i == VOTE_ADDR) |=> vote_q == $past(wdata_i[0]));

  a_r4_steady_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q >= 2'd2 && $past(req) && $past(req, 2)) |-> !stat[3]);

  a_r5_off_late: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q >= 2'd3 && $fell(stat[3])) |-> ($past(req, 2) && !$past(req, 3)));

  a_r6_code_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(stat) && !stat[2] && !stat[0]);

  a_r8_unmapped: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i && we_i && addr_i != CTRL_ADDR && addr_i != VOTE_ADDR)
      |=> ($stable(en_q) && $stable(vote_q)));
endmodule

bind branch_clk_gate branch_clk_gate_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CTRL_ADDR(CTRL_ADDR), .VOTE_ADDR(VOTE_ADDR)
) u_chk (
  .clk_i, .rst_ni, .sel_i, .we_i, .addr_i, .wdata_i, .noc_hold_i,
  .en_q, .vote_q, .stat
);

// File: tb/branch_clk_gate_tb_top.sv
module branch_clk_gate_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        sel_i = 1'b0, we_i = 1'b0, noc_hold_i = 1'b0;
  logic [3:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        clk_o;
  int n_chk = 0, n_fail = 0, pulses = 0, glitches = 0;
  logic [31:0] rd;

  always #5 clk_i = ~clk_i;

  branch_clk_gate dut_i (.*);

  always @(posedge clk_o) pulses++;
  always @(negedge clk_i) begin
    #1;
    if (clk_o) glitches++;
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk_i);
    sel_i = 1; we_i = 1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    sel_i = 0; we_i = 0;
  endtask

  task automatic rdreg(logic [3:0] a, output logic [31:0] d);
    addr_i = a;
    #2 d = rdata_o;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic t_reset;
    rdreg(4'h0, rd); check("R1 ctrl", rd, 32'h8000_0000);
    rdreg(4'h4, rd); check("R1 vote", rd, 32'h0);
    check("R1 no clk_o", pulses, 0);
  endtask

  task automatic t_enable;
    wr(4'h0, 32'h7FFF_FFFF);
    rdreg(4'h0, rd); check("R5 off after 0 edges", rd, 32'h8000_0001);
    idle(1); rdreg(4'h0, rd); check("R5 off after 1 edge", rd, 32'h8000_0001);
    idle(1); rdreg(4'h0, rd); check("R2 R6 on", rd, 32'h0000_0001);
    pulses = 0; idle(10);
    check("R7 pulses while on", pulses, 10);
    wr(4'h0, 32'h0);
    idle(1); rdreg(4'h0, rd); check("R5 still on 1 edge after disable", rd, 32'h0);
    idle(1); rdreg(4'h0, rd); check("R5 off 2 edges after disable", rd, 32'h8000_0000);
    idle(1); pulses = 0; idle(10);
    check("R7 no pulses while off", pulses, 0);
  endtask

  task automatic t_vote;
    wr(4'h4, 32'hFFFF_FFFF);
    rdreg(4'h4, rd); check("R3 vote readback", rd, 32'h1);
    idle(2); rdreg(4'h0, rd); check("R4 R6 vote runs", rd, 32'h0);
    pulses = 0; idle(5); check("R4 vote pulses", pulses, 5);
    wr(4'h4, 32'h0); idle(3);
    rdreg(4'h0, rd); check("R4 vote off", rd, 32'h8000_0000);
  endtask

  task automatic t_hold;
    @(negedge clk_i); noc_hold_i = 1;
    idle(2); rdreg(4'h0, rd); check("R6 noc held code", rd, 32'h2000_0000);
    pulses = 0; idle(5); check("R4 hold pulses", pulses, 5);
    wr(4'h0, 32'h1); idle(2);
    rdreg(4'h0, rd); check("R6 enable overrides held code", rd, 32'h0000_0001);
    wr(4'h0, 32'h0); idle(2);
    rdreg(4'h0, rd); check("R6 back to held code", rd, 32'h2000_0000);
    @(negedge clk_i); noc_hold_i = 0;
    idle(3); rdreg(4'h0, rd); check("R6 off code", rd, 32'h8000_0000);
  endtask

  task automatic t_unmapped;
    wr(4'h8, 32'hFFFF_FFFF); wr(4'h1, 32'hFFFF_FFFF); wr(4'hC, 32'hFFFF_FFFF);
    rdreg(4'h8, rd); check("R8 unmapped read", rd, 32'h0);
    rdreg(4'h0, rd); check("R8 ctrl untouched", rd, 32'h8000_0000);
    rdreg(4'h4, rd); check("R8 vote untouched", rd, 32'h0);
  endtask

  initial begin
    fork
      begin
        #1_000_000;
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
      end
    join_none
    idle(3);
    t_reset;
    rst_ni = 1;
    idle(2);
    t_enable;
    t_vote;
    t_hold;
    t_unmapped;
    check("R7 no high clk_o in low phase", glitches, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule